// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

A combinational integer ALU for the data-processing stage of a load/store processor. In one evaluation it takes an operation code, a first operand, a second operand that the shifter in front of it has already prepared, that shifter's carry-out, the current status word, a flag-update enable and the program counter. It returns the result, a destination write-enable and the next status word.

The four condition flags are negative, zero, carry and overflow. Their source depends on the class of the operation. Arithmetic operations take carry and overflow from one wide addition. For subtraction that addition uses inverted operands, so a set carry means no borrow. Logical and move operations take carry from the shifter and keep the old overflow. Compare and test operations update the flags but never write a destination.

The opcode is 5 bits wide, because the nineteen operations do not fit in 4 bits. Codes 19 to 31 are unused. An unused code writes nothing, changes no flag and drives a zero result.

Top module: `dp_alu`

## Requirements
- R1: The flags sit in the status word at negative = bit 31, zero = bit 30, carry = bit 29 and overflow = bit 28, and bits 27:0 always pass from `flags_in` to `flags_out`. When flags update, negative = result bit 31 and zero = 1 only for an all-zero 32-bit result.
- R2: When `set_flags` = 0, `flags_out` equals `flags_in` for every opcode.
- R3: ADD (4), ADC (5) and CMN (11) compute a + b + cin, where cin = 0 for ADD and CMN and cin = old carry (bit 29) for ADC. Carry is bit 32 of the 33-bit sum. Overflow is set when the exact signed sum lies outside the 32-bit signed range.
- R4: SUB (2), SBC (6) and CMP (10) compute a − b − borrow. The borrow is 0 for SUB and CMP and is the inverse of the old carry for SBC. Carry = 1 exactly when unsigned a ≥ b + borrow, which is one addition of a, ~b and the carry-in. Overflow is set when the exact signed difference lies outside the 32-bit signed range.
- R5: RSB (3) and RSC (7) compute b − a − borrow, using the same borrow rule as R4 with the operands swapped, for both carry and overflow.
- R6: The logical operations are AND (0), EOR (1), ORR (12), MOV (13, result b), BIC (14, a & ~b), MVN (15, ~b), ORN (16, a | ~b), TST (8) and TEQ (9). With flags enabled, they set carry to `shift_cout` and keep overflow.
- R7: TST, TEQ, CMP and CMN update flags like AND, EOR, SUB and ADD, but hold `wr_en` = 0. Every other defined opcode holds `wr_en` = 1.
- R8: MOVT (17) returns {b[15:0], a[15:0]} and updates flags like a logical operation.
- R9: ADR (18) returns (pc & ~3) + b when a[0] = 1 and (pc & ~3) − b when a[0] = 0, modulo 2^32, and updates flags like a logical operation.
- R10: Opcodes 19 to 31 give result = 0, `wr_en` = 0 and `flags_out` = `flags_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 5 | Operation code |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Pre-shifted second operand |
| shift_cout | input | 1 | Carry-out of the operand shifter |
| flags_in | input | 32 | Current status word |
| set_flags | input | 1 | Flag-setting form when 1 |
| pc | input | 32 | Program counter |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Destination write-enable |
| flags_out | output | 32 | Next status word |

## Verification
On every input change the assertions check four things: the low 27:0 status bits pass through, the whole word holds when `set_flags` = 0, compare and test operations never write, and logical operations with flags enabled keep overflow. They also check that unused codes stay inert and that the zero flag agrees with the result. Only the bench's scenarios can show that the arithmetic values, carries and overflows are right. Among them are signed-overflow edges, subtract-with-carry with carry-in 0 at the zero operand boundary, the reverse-subtract operand order, the halfword placement of MOVT and both directions of ADR.

// File: rtl/dp_alu_pkg.sv
// Shared opcode encoding and classification helpers for the data-processing ALU.
// Assumes a 5-bit opcode space with codes above ADR unused.
package dp_alu_pkg;
    localparam int OPW = 5;

    typedef enum logic [OPW-1:0] {
        OP_AND  = 5'd0,  OP_EOR  = 5'd1,  OP_SUB = 5'd2,  OP_RSB = 5'd3,
        OP_ADD  = 5'd4,  OP_ADC  = 5'd5,  OP_SBC = 5'd6,  OP_RSC = 5'd7,
        OP_TST  = 5'd8,  OP_TEQ  = 5'd9,  OP_CMP = 5'd10, OP_CMN = 5'd11,
        OP_ORR  = 5'd12, OP_MOV  = 5'd13, OP_BIC = 5'd14, OP_MVN = 5'd15,
        OP_ORN  = 5'd16, OP_MOVT = 5'd17, OP_ADR = 5'd18
    } alu_op_e;

    // Opcode lies in the defined range
    function automatic logic op_known(input logic [OPW-1:0] o);
        return o <= OP_ADR;
    endfunction

    // Opcode takes carry and overflow from the adder
    function automatic logic op_arith(input logic [OPW-1:0] o);
        return (o >= OP_SUB && o <= OP_RSC) || o == OP_CMP || o == OP_CMN;
    endfunction

    // Opcode result comes from the adder datapath (arith plus ADR)
    function automatic logic op_uses_adder(input logic [OPW-1:0] o);
        return op_arith(o) || o == OP_ADR;
    endfunction

    // Opcode updates flags only and writes no destination
    function automatic logic op_no_write(input logic [OPW-1:0] o);
        return o >= OP_TST && o <= OP_CMN;
    endfunction
endpackage

// File: rtl/dp_alu_adder.sv
// One W+1-bit adder shared by every arithmetic form and the PC-relative address.
// Subtraction is an addition of an inverted operand with a carry-in, so carry
// and overflow always come from a single sum. Assumes W >= 3.
module dp_alu_adder #(
    parameter int W = 32
) (
    input  logic [dp_alu_pkg::OPW-1:0] op,
    input  logic [W-1:0]               opnd_a,
    input  logic [W-1:0]               opnd_b,
    input  logic [W-1:0]               pc,
    input  logic                       c_old,
    output logic [W-1:0]               sum,
    output logic                       c_out,
    output logic                       v_out
);
    import dp_alu_pkg::*;

    logic [W-1:0] add_x, add_y;
    logic         add_ci;
    logic [W:0]   wide;

    // Pick adder inputs and carry-in per operation
    always_comb begin
        add_x  = opnd_a;
        add_y  = opnd_b;
        add_ci = 1'b0;
        unique case (op)
            OP_ADD, OP_CMN: begin add_x = opnd_a; add_y = opnd_b;  add_ci = 1'b0;  end
            OP_ADC:         begin add_x = opnd_a; add_y = opnd_b;  add_ci = c_old; end
            OP_SUB, OP_CMP: begin add_x = opnd_a; add_y = ~opnd_b; add_ci = 1'b1;  end
            OP_SBC:         begin add_x = opnd_a; add_y = ~opnd_b; add_ci = c_old; end
            OP_RSB:         begin add_x = opnd_b; add_y = ~opnd_a; add_ci = 1'b1;  end
            OP_RSC:         begin add_x = opnd_b; add_y = ~opnd_a; add_ci = c_old; end
            OP_ADR: begin
                add_x  = {pc[W-1:2], 2'b00};
                add_y  = opnd_a[0] ? opnd_b : ~opnd_b;
                add_ci = ~opnd_a[0];
            end
            default: ;
        endcase
    end

    // Single wide sum and its signed-overflow indication
    always_comb begin
        wide  = {1'b0, add_x} + {1'b0, add_y} + {{W{1'b0}}, add_ci};
        sum   = wide[W-1:0];
        c_out = wide[W];
        v_out = (add_x[W-1] == add_y[W-1]) && (wide[W-1] != add_x[W-1]);
    end
endmodule

// File: rtl/dp_alu_logic.sv
// Bitwise, move and move-top results. Assumes W is even.
module dp_alu_logic #(
    parameter int W = 32
) (
    input  logic [dp_alu_pkg::OPW-1:0] op,
    input  logic [W-1:0]               opnd_a,
    input  logic [W-1:0]               opnd_b,
    output logic [W-1:0]               res
);
    import dp_alu_pkg::*;
    localparam int HALF = W / 2;

    // Select the bitwise function
    always_comb begin
        unique case (op)
            OP_AND, OP_TST: res = opnd_a & opnd_b;
            OP_EOR, OP_TEQ: res = opnd_a ^ opnd_b;
            OP_ORR:         res = opnd_a | opnd_b;
            OP_ORN:         res = opnd_a | ~opnd_b;
            OP_BIC:         res = opnd_a & ~opnd_b;
            OP_MOV:         res = opnd_b;
            OP_MVN:         res = ~opnd_b;
            OP_MOVT:        res = {opnd_b[HALF-1:0], opnd_a[HALF-1:0]};
            default:        res = '0;
        endcase
    end
endmodule

// File: rtl/dp_alu_flags.sv
// Builds the next status word: the top four bits are negative, zero, carry
// and overflow, and the rest pass through. Carry and overflow come from the
// adder for arithmetic operations and from the shifter/old value otherwise.
module dp_alu_flags #(
    parameter int W = 32
) (
    input  logic [W-1:0] res,
    input  logic         upd,
    input  logic         arith,
    input  logic         add_c,
    input  logic         add_v,
    input  logic         shift_c,
    input  logic [W-1:0] flags_in,
    output logic [W-1:0] flags_out
);
    localparam int BN = W - 1;
    localparam int BZ = W - 2;
    localparam int BC = W - 3;
    localparam int BV = W - 4;

    logic f_n, f_z, f_c, f_v;

    // Per-class flag sources
    always_comb begin
        f_n = res[BN];
        f_z = (res == '0);
        f_c = arith ? add_c : shift_c;
        f_v = arith ? add_v : flags_in[BV];
    end

    // Merge into status word or hold it
    always_comb begin
        flags_out = flags_in;
        if (upd) begin
            flags_out[BN] = f_n;
            flags_out[BZ] = f_z;
            flags_out[BC] = f_c;
            flags_out[BV] = f_v;
        end
    end
endmodule

// File: rtl/dp_alu.sv
// Data-processing ALU top: routes operands to the adder or the logic unit,
// selects the result, derives the write-enable and the flag update.
// Purely combinational; assumes operand 2 is already shifted upstream.
module dp_alu #(
    parameter int W = 32
) (
    input  logic [4:0]   op,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic         shift_cout,
    input  logic [W-1:0] flags_in,
    input  logic         set_flags,
    input  logic [W-1:0] pc,
    output logic [W-1:0] result,
    output logic         wr_en,
    output logic [W-1:0] flags_out
);
    import dp_alu_pkg::*;
    localparam int BZ = W - 2;
    localparam int BC = W - 3;
    localparam int BV = W - 4;

    logic [W-1:0] add_sum, log_res;
    logic         add_c, add_v;
    logic         known, arith, via_adder, quiet;

    dp_alu_adder #(.W(W)) u_adder (
        .op(op), .opnd_a(opnd_a), .opnd_b(opnd_b), .pc(pc),
        .c_old(flags_in[BC]), .sum(add_sum), .c_out(add_c), .v_out(add_v)
    );

    dp_alu_logic #(.W(W)) u_logic (
        .op(op), .opnd_a(opnd_a), .opnd_b(opnd_b), .res(log_res)
    );

    // Classify the opcode
    always_comb begin
        known     = op_known(op);
        arith     = op_arith(op);
        via_adder = op_uses_adder(op);
        quiet     = op_no_write(op);
    end

    // Result select and destination write-enable
    always_comb begin
        if (!known)         result = '0;
        else if (via_adder) result = add_sum;
        else                result = log_res;
        wr_en = known && !quiet;
    end

    dp_alu_flags #(.W(W)) u_flags (
        .res(result), .upd(set_flags && known), .arith(arith),
        .add_c(add_c), .add_v(add_v), .shift_c(shift_cout),
        .flags_in(flags_in), .flags_out(flags_out)
    );

    // Output consistency checks
    always_comb begin
        AST_LOW_PASS: assert (flags_out[BV-1:0] == flags_in[BV-1:0]) else $error("low status bits changed"); // R1
        AST_ZERO_FLAG: assert (!(set_flags && known) || (flags_out[BZ] == (result == '0))) else $error("zero flag mismatch"); // R1
        AST_HOLD_FLAGS: assert (set_flags || flags_out == flags_in) else $error("flags moved without set_flags"); // R2
        AST_KEEP_V: assert (!(set_flags && known && !arith) || flags_out[BV] == flags_in[BV]) else $error("logical op changed V"); // R6
        AST_NO_WRITE: assert (!quiet || !wr_en) else $error("compare/test wrote"); // R7
        AST_UNUSED_INERT: assert (known || (!wr_en && result == '0 && flags_out == flags_in)) else $error("unused opcode active"); // R10
    end
endmodule

// File: tb/dp_alu_tb.sv
// Self-checking bench: directed corners plus seeded random vectors against a
// behavioural model built from the requirements.
module dp_alu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op;
    logic [31:0] opnd_a, opnd_b, flags_in, pc;
    logic        shift_cout, set_flags;
    logic [31:0] result, flags_out;
    logic        wr_en;
    int          total = 0, bad = 0;

    always #5 clk = ~clk;

    dp_alu u_dut (
        .op(op), .opnd_a(opnd_a), .opnd_b(opnd_b), .shift_cout(shift_cout),
        .flags_in(flags_in), .set_flags(set_flags), .pc(pc),
        .result(result), .wr_en(wr_en), .flags_out(flags_out)
    );

    logic [31:0] e_res, e_flags;
    logic        e_wr;

    // Requirement tag for an opcode
    function automatic string tag_of(input logic [4:0] o);
        if (o > 5'd18) return "R10";
        case (o)
            5'd4, 5'd5, 5'd11: return "R3";
            5'd2, 5'd6, 5'd10: return "R4";
            5'd3, 5'd7:        return "R5";
            5'd17:             return "R8";
            5'd18:             return "R9";
            default:           return "R6";
        endcase
    endfunction

    // Behavioural model of all operations
    task automatic model(input logic [4:0] o, input logic [31:0] a, input logic [31:0] b,
                         input logic sc, input logic [31:0] fi, input logic sf,
                         input logic [31:0] p);
        longint sv, ua, ub;
        logic   ci, c, v, arith;
        ci = fi[29];
        c = sc; v = fi[28]; arith = 1'b0;
        e_wr = 1'b1;
        e_res = 32'h0;
        case (o)
            5'd0, 5'd8:  e_res = a & b;
            5'd1, 5'd9:  e_res = a ^ b;
            5'd12: e_res = a | b;
            5'd13: e_res = b;
            5'd14: e_res = a & ~b;
            5'd15: e_res = ~b;
            5'd16: e_res = a | ~b;
            5'd17: e_res = {b[15:0], a[15:0]};
            5'd18: e_res = a[0] ? ((p & 32'hFFFF_FFFC) + b) : ((p & 32'hFFFF_FFFC) - b);
            5'd4, 5'd5, 5'd11: begin
                arith = 1'b1;
                ua = longint'(a) + longint'(b) + ((o == 5'd5) ? longint'(ci) : 0);
                sv = longint'($signed(a)) + longint'($signed(b)) + ((o == 5'd5) ? longint'(ci) : 0);
                e_res = ua[31:0];
                c = ua > 64'hFFFF_FFFF;
                v = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
            end
            5'd2, 5'd6, 5'd10, 5'd3, 5'd7: begin
                arith = 1'b1;
                if (o == 5'd3 || o == 5'd7) begin ua = longint'(b); ub = longint'(a);
                    sv = longint'($signed(b)) - longint'($signed(a)); end
                else begin ua = longint'(a); ub = longint'(b);
                    sv = longint'($signed(a)) - longint'($signed(b)); end
                if (o == 5'd6 || o == 5'd7) begin ub = ub + longint'(!ci); sv = sv - longint'(!ci); end
                e_res = 32'(ua - ub);
                c = ua >= ub;
                v = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
            end
            default: e_wr = 1'b0;
        endcase
        if (o >= 5'd8 && o <= 5'd11) e_wr = 1'b0;
        e_flags = fi;
        if (sf && o <= 5'd18) begin
            e_flags[31] = e_res[31];
            e_flags[30] = (e_res == 32'h0);
            e_flags[29] = c;
            e_flags[28] = arith ? v : fi[28];
        end
    endtask

    task automatic check(input string tg, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s op=%0d actual=%h expected=%h", tg, what, op, act, exp);
        end
    endtask

    // Apply one vector on a rising edge, compare on the next falling edge
    task automatic run(input logic [4:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic sc, input logic [31:0] fi, input logic sf,
                       input logic [31:0] p);
        string tg;
        @(posedge clk);
        op = o; opnd_a = a; opnd_b = b; shift_cout = sc; flags_in = fi; set_flags = sf; pc = p;
        @(negedge clk);
        model(o, a, b, sc, fi, sf, p);
        tg = tag_of(o);
        check(tg, "result", result, e_res);
        check((o >= 5'd8 && o <= 5'd11) ? "R7" : tg, "wr_en", {31'b0, wr_en}, {31'b0, e_wr});
        check(sf ? tg : "R2", "flags", flags_out, e_flags);
        check("R1", "low_bits", {4'h0, flags_out[27:0]}, {4'h0, fi[27:0]});
    endtask

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        op = 0; opnd_a = 0; opnd_b = 0; shift_cout = 0; flags_in = 0; set_flags = 0; pc = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset-state style check: all-zero inputs, AND, no flag update (R2)
        run(5'd0, 32'h0, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0);
        // R3 signed overflow edge and unsigned carry
        run(5'd4, 32'h7FFF_FFFF, 32'h1, 1'b0, 32'h0, 1'b1, 0);
        run(5'd4, 32'hFFFF_FFFF, 32'h1, 1'b0, 32'h0, 1'b1, 0);
        run(5'd5, 32'h7FFF_FFFF, 32'h0, 1'b0, 32'h2000_0000, 1'b1, 0);
        // R4 borrow cases and subtract-with-carry with carry-in 0
        run(5'd2, 32'h0, 32'h1, 1'b1, 32'h0, 1'b1, 0);
        run(5'd6, 32'h5, 32'h3, 1'b0, 32'h0, 1'b1, 0);
        run(5'd6, 32'h0, 32'h0, 1'b1, 32'h0, 1'b1, 0);
        run(5'd10, 32'h8000_0000, 32'h1, 1'b0, 32'h0, 1'b1, 0);
        // R5 operand order
        run(5'd3, 32'h3, 32'hA, 1'b0, 32'h0, 1'b1, 0);
        run(5'd7, 32'h0, 32'h0, 1'b0, 32'h0, 1'b1, 0);
        // R6 shifter carry and kept overflow, R7 no write
        run(5'd8, 32'hF0, 32'h0F, 1'b1, 32'h1000_0000, 1'b1, 0);
        run(5'd16, 32'h0, 32'hFFFF_FFFF, 1'b1, 32'h1234_5678, 1'b1, 0);
        // R8 move-top, R9 both directions
        run(5'd17, 32'hAAAA_1234, 32'h5555_BEEF, 1'b0, 32'h0, 1'b1, 0);
        run(5'd18, 32'h1, 32'h10, 1'b0, 32'h0, 1'b1, 32'h0000_1003);
        run(5'd18, 32'h0, 32'h10, 1'b0, 32'h0, 1'b1, 32'h0000_1003);
        // R10 unused codes with flags requested
        run(5'd19, 32'h1, 32'h1, 1'b1, 32'hA5A5_A5A5, 1'b1, 0);
        run(5'd31, 32'hFFFF_FFFF, 32'h1, 1'b1, 32'h5A5A_5A5A, 1'b1, 0);
        // Constrained random over all codes
        for (int i = 0; i < 3000; i++) begin
            logic [4:0] ro;
            ro = (($urandom % 8) == 0) ? 5'($urandom) : 5'($urandom % 19);
            run(ro, $urandom, (($urandom % 4) == 0) ? 32'h0 : $urandom, 1'($urandom),
                $urandom, 1'($urandom), $urandom);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule